// File: doc/BRIEF.md
# Command-Sequence Write Guard

This block sits beside the write controller of a byte-wide non-volatile memory and watches every byte load that the controller decodes. It looks for two fixed command sequences, each a series of specific data bytes written to specific addresses. A three-load key sets protection, and a six-load key clears it. It keeps the protection state and, for every load, decides whether that byte may be committed to the array.

While protection is set, a page load is committed only if the three-load key comes directly before it. A load without the key still lets the write controller run its full internal busy period, but the guard holds its commit permit low, so nothing reaches the array. Command bytes are swallowed and are never written anywhere. A change of protection state is held pending and takes effect when the write controller signals the end of the internal write cycle, whether or not data bytes followed the key. The `cycle_end` pulse also closes the page: the one-page write permit is dropped and the matcher returns to idle.

Each load gets its verdict one clock after it is presented: `commit_ok` pulses for a byte that may be written, and `cmd_taken` pulses for a byte that was used as a command. A load that is refused raises neither pulse.

Top module: `cmdseq_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `prot_on`, `commit_ok` and `cmd_taken` are all 0. Protection starts cleared.
- R2: `commit_ok` and `cmd_taken` are single-cycle pulses that appear only on the cycle after a load (`wr_valid`=1) and are never high together.
- R3: The set key is three loads: data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Each of these loads raises `cmd_taken` and not `commit_ok`.
- R4: After the set key has completed, `prot_on` stays unchanged until a `cycle_end` pulse. It reads 1 on the cycle after that pulse.
- R5: The clear key is six loads: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. Each of them raises `cmd_taken`. `prot_on` reads 0 on the cycle after the next `cycle_end`.
- R6: While `prot_on` is 1 and no key has completed since the last `cycle_end`, a non-command load raises neither `commit_ok` nor `cmd_taken`.
- R7: Once the set key has completed, the later loads up to the next `cycle_end` raise `commit_ok`, even when protection is on. The same holds after the clear key.
- R8: A load that does not match the next expected key byte sends the matcher back to idle and is judged as a data load. It is not compared against the first key byte.
- R9: After either key completes, loads that look like key bytes are data loads until the next `cycle_end`.
- R10: While `prot_on` is 0, every load that is not taken as a command raises `commit_ok`.
- R11: When `cycle_end` and a load fall in the same cycle, the end of the cycle is applied first: the pending state change lands, the one-page permit drops, and the matcher returns to idle. The load is then judged against that new state.
- R12: Protection stays set across any number of `cycle_end` pulses until the clear key is completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | One-cycle strobe for a decoded byte load |
| wr_addr | input | ADDR_W (15) | Address of the byte load |
| wr_data | input | DATA_W (8) | Data of the byte load |
| cycle_end | input | 1 | Pulse from the write timer at the end of the internal write cycle |
| prot_on | output | 1 | Protection state |
| commit_ok | output | 1 | Pulse: the previous load may be written to the array |
| cmd_taken | output | 1 | Pulse: the previous load was used as a command byte |

## Verification
The end-of-cycle pulse and a byte load can arrive in the same cycle. In that case a pending state change, the drop of the one-page permit and the reset of the matcher all have to take effect before the load is judged. The bench provokes this by completing the set key with protection off and then presenting a plain data load in the very cycle that `cycle_end` pulses. It expects that load to be refused, with neither pulse raised, and expects `prot_on` to read 1 on the same cycle as the verdict. A checker property also requires that, whenever the verdict of a load comes with protection off, one of the two pulses is present.

// File: rtl/cmdseq_guard_pkg.sv
package cmdseq_guard_pkg;

    // Matcher position: how much of a key has been seen so far.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // nothing matched
        ST_K1   = 3'd1,   // first key byte seen
        ST_K2   = 3'd2,   // second key byte seen, set/extend fork
        ST_X1   = 3'd3,   // extend byte seen (clear path)
        ST_X2   = 3'd4,
        ST_X3   = 3'd5,
        ST_DONE = 3'd6    // a key completed; matching parked until cycle end
    } step_t;

    typedef struct packed {
        step_t step;
        logic  prot;      // protection state
        logic  pend_set;  // set lands at next cycle end
        logic  pend_clr;  // clear lands at next cycle end
        logic  unlock;    // one-page write permit
        logic  commit;    // verdict pulse: write allowed
        logic  consumed;  // verdict pulse: command byte
    } state_t;

    localparam state_t STATE_RST = '{step: ST_IDLE, default: 1'b0};

endpackage

// File: rtl/cmdseq_step_match.sv
module cmdseq_step_match
    import cmdseq_guard_pkg::*;
#(
    parameter int                ADDR_W  = 15,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] ADDR_HI = 15'h5555,
    parameter logic [ADDR_W-1:0] ADDR_LO = 15'h2AAA,
    parameter logic [DATA_W-1:0] KEY_A   = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_B   = 8'h55,
    parameter logic [DATA_W-1:0] OP_SET  = 8'hA0,
    parameter logic [DATA_W-1:0] OP_EXT  = 8'h80,
    parameter logic [DATA_W-1:0] OP_CLR  = 8'h20
) (
    input  step_t             cur,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit,
    output step_t             nxt,
    output logic              fin_set,
    output logic              fin_clr
);

    logic at_hi;
    logic at_lo;

    assign at_hi = (addr == ADDR_HI);
    assign at_lo = (addr == ADDR_LO);

    always_comb begin
        hit     = 1'b0;
        nxt     = cur;
        fin_set = 1'b0;
        fin_clr = 1'b0;
        unique case (cur)
            ST_IDLE: if (at_hi && data == KEY_A) begin
                hit = 1'b1;
                nxt = ST_K1;
            end
            ST_K1: if (at_lo && data == KEY_B) begin
                hit = 1'b1;
                nxt = ST_K2;
            end
            ST_K2: begin
                if (at_hi && data == OP_SET) begin
                    hit     = 1'b1;
                    nxt     = ST_DONE;
                    fin_set = 1'b1;
                end else if (at_hi && data == OP_EXT) begin
                    hit = 1'b1;
                    nxt = ST_X1;
                end
            end
            ST_X1: if (at_hi && data == KEY_A) begin
                hit = 1'b1;
                nxt = ST_X2;
            end
            ST_X2: if (at_lo && data == KEY_B) begin
                hit = 1'b1;
                nxt = ST_X3;
            end
            ST_X3: if (at_hi && data == OP_CLR) begin
                hit     = 1'b1;
                nxt     = ST_DONE;
                fin_clr = 1'b1;
            end
            default: ;  // ST_DONE: parked, nothing matches
        endcase
    end

endmodule

// File: rtl/cmdseq_cycle_close.sv
module cmdseq_cycle_close
    import cmdseq_guard_pkg::*;
(
    input  state_t cur,
    input  logic   fire,
    output state_t nxt
);

    // Applies the end-of-write-cycle effects before any load of the same cycle.
    always_comb begin
        nxt = cur;
        if (fire) begin
            if (cur.pend_set) nxt.prot = 1'b1;
            if (cur.pend_clr) nxt.prot = 1'b0;
            nxt.pend_set = 1'b0;
            nxt.pend_clr = 1'b0;
            nxt.unlock   = 1'b0;
            nxt.step     = ST_IDLE;
        end
    end

endmodule

// File: rtl/cmdseq_guard.sv
module cmdseq_guard
    import cmdseq_guard_pkg::*;
#(
    parameter int                ADDR_W  = 15,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] ADDR_HI = 15'h5555,
    parameter logic [ADDR_W-1:0] ADDR_LO = 15'h2AAA,
    parameter logic [DATA_W-1:0] KEY_A   = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_B   = 8'h55,
    parameter logic [DATA_W-1:0] OP_SET  = 8'hA0,
    parameter logic [DATA_W-1:0] OP_EXT  = 8'h80,
    parameter logic [DATA_W-1:0] OP_CLR  = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cycle_end,
    output logic              prot_on,
    output logic              commit_ok,
    output logic              cmd_taken
);

    state_t st_q;
    state_t st_d;
    state_t st_mid;

    logic  m_hit;
    step_t m_nxt;
    logic  m_set;
    logic  m_clr;

    cmdseq_cycle_close u_close (
        .cur  (st_q),
        .fire (cycle_end),
        .nxt  (st_mid)
    );

    cmdseq_step_match #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W),
        .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO),
        .KEY_A  (KEY_A), .KEY_B (KEY_B),
        .OP_SET (OP_SET), .OP_EXT(OP_EXT), .OP_CLR(OP_CLR)
    ) u_match (
        .cur     (st_mid.step),
        .addr    (wr_addr),
        .data    (wr_data),
        .hit     (m_hit),
        .nxt     (m_nxt),
        .fin_set (m_set),
        .fin_clr (m_clr)
    );

    always_comb begin
        st_d          = st_mid;
        st_d.commit   = 1'b0;
        st_d.consumed = 1'b0;
        if (wr_valid) begin
            if (m_hit) begin
                st_d.consumed = 1'b1;
                st_d.step     = m_nxt;
                if (m_set) begin
                    st_d.pend_set = 1'b1;
                    st_d.pend_clr = 1'b0;
                    st_d.unlock   = 1'b1;
                end
                if (m_clr) begin
                    st_d.pend_clr = 1'b1;
                    st_d.pend_set = 1'b0;
                    st_d.unlock   = 1'b1;
                end
            end else begin
                st_d.step   = (st_mid.step == ST_DONE) ? ST_DONE : ST_IDLE;
                st_d.commit = !st_mid.prot || st_mid.unlock;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STATE_RST;
        else        st_q <= st_d;
    end

    assign prot_on   = st_q.prot;
    assign commit_ok = st_q.commit;
    assign cmd_taken = st_q.consumed;

endmodule

// File: rtl/cmdseq_guard_chk.sv
module cmdseq_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic cycle_end,
    input logic prot_on,
    input logic commit_ok,
    input logic cmd_taken
);

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!prot_on && !commit_ok && !cmd_taken);
        end
    end

    // R2
    no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_ok && cmd_taken));

    // R2
    pulse_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ok || cmd_taken) |-> $past(wr_valid));

    // R4 R5 R12
    prot_moves_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_on) |-> $past(cycle_end));

    // R10
    open_load_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_valid) && !prot_on) |-> (commit_ok || cmd_taken));

endmodule

bind cmdseq_guard cmdseq_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .cycle_end (cycle_end),
    .prot_on   (prot_on),
    .commit_ok (commit_ok),
    .cmd_taken (cmd_taken)
);

// File: tb/cmdseq_guard_tb.sv
module cmdseq_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cycle_end = 1'b0;
    logic        prot_on;
    logic        commit_ok;
    logic        cmd_taken;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic vld_seen = 1'b0;

    typedef struct {
        logic  c;
        logic  t;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;  // 250 MHz

    cmdseq_guard u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .cycle_end(cycle_end), .prot_on(prot_on),
        .commit_ok(commit_ok), .cmd_taken(cmd_taken)
    );

    always @(posedge clk) vld_seen <= wr_valid;

    // Monitor: compare each verdict against the scoreboard, and demand silence otherwise.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (vld_seen) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (commit_ok !== e.c || cmd_taken !== e.t) begin
                    n_fail++;
                    $display("FAIL %s: commit/taken=%b%b expected %b%b",
                             e.tag, commit_ok, cmd_taken, e.c, e.t);
                end
            end else if (commit_ok || cmd_taken) begin
                n_chk++;
                n_fail++;
                $display("FAIL R2: pulse without load commit/taken=%b%b expected 00",
                         commit_ok, cmd_taken);
            end
        end
    end

    task automatic load(input logic [14:0] a, input logic [7:0] d,
                        input logic ec, input logic et, input string tag,
                        input logic with_end = 1'b0);
        exp_t e;
        @(negedge clk);
        wr_valid  = 1'b1;
        wr_addr   = a;
        wr_data   = d;
        cycle_end = with_end;
        e.c = ec; e.t = et; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        wr_valid  = 1'b0;
        cycle_end = 1'b0;
    endtask

    task automatic end_cycle();
        @(negedge clk);
        cycle_end = 1'b1;
        @(negedge clk);
        cycle_end = 1'b0;
    endtask

    task automatic chk_prot(input logic ex, input string tag);
        n_chk++;
        if (prot_on !== ex) begin
            n_fail++;
            $display("FAIL %s: prot_on=%b expected %b", tag, prot_on, ex);
        end
    endtask

    task automatic set_key(input logic [2:0] lp, input string tag);
        load(15'h5555, 8'hAA, 1'b0, 1'b1, tag);
        load(15'h2AAA, 8'h55, 1'b0, 1'b1, tag);
        load(15'h5555, 8'hA0, 1'b0, 1'b1, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        n_chk++;
        if (prot_on !== 1'b0 || commit_ok !== 1'b0 || cmd_taken !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: outputs=%b%b%b expected 000", prot_on, commit_ok, cmd_taken);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk_prot(1'b0, "R1");

        load(15'h0123, 8'h5A, 1'b1, 1'b0, "R10 open data");
        set_key(3'd0, "R3 set key byte");
        load(15'h0040, 8'h3C, 1'b1, 1'b0, "R7 data after key");
        chk_prot(1'b0, "R4 pending before end");
        end_cycle();
        chk_prot(1'b1, "R4 set after end");

        load(15'h0100, 8'h11, 1'b0, 1'b0, "R6 keyless load refused");
        load(15'h0101, 8'h12, 1'b0, 1'b0, "R6 keyless load refused");
        end_cycle();
        chk_prot(1'b1, "R12 holds across end");

        set_key(3'd0, "R3 set key protected");
        load(15'h0140, 8'h21, 1'b1, 1'b0, "R7 permitted page byte");
        load(15'h5555, 8'hAA, 1'b1, 1'b0, "R9 key-like byte is data");
        load(15'h2AAA, 8'h55, 1'b1, 1'b0, "R9 key-like byte is data");
        end_cycle();
        chk_prot(1'b1, "R12 holds after keyed page");

        load(15'h5555, 8'hAA, 1'b0, 1'b1, "R8 first key byte");
        load(15'h0100, 8'h12, 1'b0, 1'b0, "R8 mismatch is data, refused");
        load(15'h2AAA, 8'h55, 1'b0, 1'b0, "R8 matcher back at idle");
        end_cycle();
        chk_prot(1'b1, "R12 holds after mismatch");

        load(15'h5555, 8'hAA, 1'b0, 1'b1, "R5 clear key byte");
        load(15'h2AAA, 8'h55, 1'b0, 1'b1, "R5 clear key byte");
        load(15'h5555, 8'h80, 1'b0, 1'b1, "R5 clear key byte");
        load(15'h5555, 8'hAA, 1'b0, 1'b1, "R5 clear key byte");
        load(15'h2AAA, 8'h55, 1'b0, 1'b1, "R5 clear key byte");
        load(15'h5555, 8'h20, 1'b0, 1'b1, "R5 clear key byte");
        load(15'h0200, 8'h44, 1'b1, 1'b0, "R7 data after clear key");
        chk_prot(1'b1, "R5 pending before end");
        end_cycle();
        chk_prot(1'b0, "R5 cleared after end");

        load(15'h5555, 8'hAA, 1'b0, 1'b1, "R8 first key byte, open");
        load(15'h0200, 8'h77, 1'b1, 1'b0, "R8 mismatch written when open");
        end_cycle();

        set_key(3'd0, "R3 set key before collision");
        load(15'h0300, 8'h99, 1'b0, 1'b0, "R11 load with cycle end refused", 1'b1);
        chk_prot(1'b1, "R11 set lands first");
        end_cycle();
        load(15'h0301, 8'h9A, 1'b0, 1'b0, "R6 refused after collision");
        end_cycle();

        repeat (2) @(negedge clk);
        n_chk++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: %0d verdicts missing expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule